// File: doc/BRIEF.md
# Host Shared Memory Window Decoder

This block sits between a host bus front end that has already decoded memory transactions and a local shared memory. Each request carries a cycle type (plain memory cycle or firmware-hub cycle), a 32-bit address, a direction, a 4-bit firmware-hub ID and a completion strobe. In the same cycle as the request, the block reports whether the request falls into an enabled window. It also reports which window matched and the address to use for the local memory.

There are three windows. The first is a user zone, set by a base address and a power-of-two size. Its translated address has every bit at or above the size forced to one. The second is the low firmware area just below 1 MB: the top 64 KB is always part of it, and the 64 KB beneath that is included only when an extension bit is set. The third is the firmware area in the top 2 MB of the address space. Memory cycles and firmware-hub cycles can both reach the top area.

A small state machine watches for the first completed firmware read after host reset. It then clears the enable that belongs to the boot protocol that was not used. After that it stays idle until the next reset, and software may rewrite either enable at any time.

The configuration byte has these fields:

- bit 0: memory-cycle firmware enable
- bit 1: user-zone enable
- bit 2: low-firmware extension enable
- bit 3: firmware-hub firmware enable
- bits 7:4: the firmware-hub ID to match

Region codes are 0 for none, 1 for the user zone, 2 for low firmware and 3 for top firmware.

Top module: `shm_window_decode`

## Requirements
- R1: During and after host reset, the configuration byte reads 0x09 when `boot_strap` is nonzero and 0x00 when it is zero. At the same time `det_done` is 0, which is the state machine's WAIT_FIRST state.
- R2: When `cfg_we` is high at a clock edge, the configuration byte takes `cfg_wdata` on that edge. A write takes priority over a clear made by the detector on the same edge.
- R3: A memory cycle (`req_hub`=0) whose address is in 0x000F0000–0x000FFFFF hits with region 2 when bit 0 is set. The translated address equals the request address.
- R4: A memory cycle in 0x000E0000–0x000EFFFF hits with region 2 only when both bit 0 and bit 2 are set.
- R5: A memory cycle with address bits 31:21 all ones hits with region 3 when bit 0 is set. The translated address equals the request address.
- R6: A firmware-hub cycle (`req_hub`=1) hits with region 3 only when bit 3 is set and `req_id` equals bits 7:4. Its translated address is request bits 20:0 with bits 31:21 set to ones. A firmware-hub cycle never hits any other window.
- R7: A memory cycle hits the user zone (region 1) when bit 1 is set and the address matches `usr_base` above the block size. The block size is 2^`usr_size_log2`, clamped to the range 2^12 to 2^24. The user zone takes priority over both firmware windows.
- R8: For a user-zone hit, the translated address is the request address with every bit at or above the block size set to one.
- R9: In WAIT_FIRST, a firmware read (region 2 or 3, `req_write`=0) on a memory cycle with `req_done`=1 clears bit 3 and moves the state machine to DONE (`det_done`=1).
- R10: In WAIT_FIRST, a firmware read with `req_done`=1 on a firmware-hub cycle clears bit 0 and moves the state machine to DONE.
- R11: The following never change the enables or the state machine: a miss, a write, a read without `req_done`, a user-zone read, and any firmware read made in DONE. The DONE state holds until reset.
- R12: When there is no hit, including whenever `req_valid` is low, `hit`=0, `region`=0 and `xlat_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Host-domain reset, active low, asynchronous |
| boot_strap | input | 2 | Boot-mode strap; nonzero enables firmware sharing at reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write data |
| usr_base | input | 32 | User zone base address |
| usr_size_log2 | input | 5 | User zone size as log2 in bytes |
| req_valid | input | 1 | Request present this cycle |
| req_hub | input | 1 | 1 for a firmware-hub cycle, 0 for a memory cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_done | input | 1 | Completion strobe for the request |
| req_addr | input | 32 | Request address |
| req_id | input | 4 | Firmware-hub ID field |
| hit | output | 1 | Request matches an enabled window |
| region | output | 2 | Matched window code |
| xlat_addr | output | 32 | Translated address |
| cfg_rdata | output | 8 | Current configuration byte |
| det_done | output | 1 | State machine in DONE |

## Verification
`hit`, `region` and `xlat_addr` are combinational. They are due in the same cycle as the request, so the bench drives each request just after the falling edge and compares these outputs 2 ns later. `cfg_rdata` and `det_done` change only at the following rising edge. The bench's reference model updates its copies of the configuration byte and detect state at that edge, and the next step compares them. Each step therefore checks the request decode against the pre-edge state and the register outputs against the post-edge state.

// File: rtl/shm_pkg.sv
package shm_pkg;

    localparam int ADDR_W = 32;
    localparam int CFG_W  = 8;

    localparam int CFG_LEG_EN = 0;
    localparam int CFG_USR_EN = 1;
    localparam int CFG_EXT_EN = 2;
    localparam int CFG_HUB_EN = 3;
    localparam int CFG_ID_LO  = 4;
    localparam int ID_W       = 4;

    localparam int TOP_LOW_BITS = 21;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_USER  = 2'd1,
        RGN_LOWFW = 2'd2,
        RGN_TOPFW = 2'd3
    } region_e;

    typedef enum logic {
        DET_WAIT_FIRST = 1'b0,
        DET_DONE       = 1'b1
    } det_state_e;

endpackage

// File: rtl/shm_user_zone.sv
module shm_user_zone #(
    parameter int AW       = 32,
    parameter int SZ_W     = 5,
    parameter int MIN_LOG2 = 12,
    parameter int MAX_LOG2 = 24
) (
    input  logic            enable,
    input  logic [AW-1:0]   addr,
    input  logic [AW-1:0]   base,
    input  logic [SZ_W-1:0] size_log2,
    output logic            match,
    output logic [AW-1:0]   xlat
);

    localparam logic [SZ_W-1:0] SZ_MIN = SZ_W'(MIN_LOG2);
    localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(MAX_LOG2);

    logic [SZ_W-1:0] eff_size;
    logic [AW-1:0]   low_mask;

    always_comb begin
        if (size_log2 < SZ_MIN)
            eff_size = SZ_MIN;
        else if (size_log2 > SZ_MAX)
            eff_size = SZ_MAX;
        else
            eff_size = size_log2;
    end

    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign low_mask[i] = (SZ_W'(i) < eff_size);
    end

    assign match = enable && (((addr ^ base) & ~low_mask) == '0);
    assign xlat  = addr | ~low_mask;

endmodule

// File: rtl/shm_fw_ranges.sv
module shm_fw_ranges
    import shm_pkg::*;
(
    input  logic              is_hub,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   id,
    input  logic              leg_en,
    input  logic              ext_en,
    input  logic              hub_en,
    input  logic [ID_W-1:0]   hub_id,
    output logic              low_hit,
    output logic              top_hit,
    output logic [ADDR_W-1:0] xlat
);

    localparam int HI_W = ADDR_W - TOP_LOW_BITS;

    logic in_f_seg;
    logic in_e_seg;
    logic in_top;

    assign in_f_seg = (addr[ADDR_W-1:16] == 16'h000F);
    assign in_e_seg = (addr[ADDR_W-1:16] == 16'h000E);
    assign in_top   = &addr[ADDR_W-1:TOP_LOW_BITS];

    always_comb begin
        low_hit = 1'b0;
        top_hit = 1'b0;
        xlat    = addr;
        if (is_hub) begin
            top_hit = hub_en && (id == hub_id);
            xlat    = {{HI_W{1'b1}}, addr[TOP_LOW_BITS-1:0]};
        end else begin
            low_hit = leg_en && (in_f_seg || (ext_en && in_e_seg));
            top_hit = leg_en && in_top;
        end
    end

endmodule

// File: rtl/shm_boot_detect.sv
module shm_boot_detect
    import shm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_on,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             fw_rd_evt,
    input  logic             fw_rd_hub,
    output logic [CFG_W-1:0] cfg_q,
    output logic             done
);

    det_state_e state_q;
    det_state_e state_d;
    logic       clr_leg;
    logic       clr_hub;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= DET_WAIT_FIRST;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        clr_leg = 1'b0;
        clr_hub = 1'b0;
        unique case (state_q)
            DET_WAIT_FIRST: begin
                if (fw_rd_evt) begin
                    state_d = DET_DONE;
                    clr_leg = fw_rd_hub;
                    clr_hub = !fw_rd_hub;
                end
            end
            DET_DONE: begin
                state_d = DET_DONE;
            end
            default: state_d = DET_WAIT_FIRST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q             <= '0;
            cfg_q[CFG_LEG_EN] <= strap_on;
            cfg_q[CFG_HUB_EN] <= strap_on;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end else begin
            if (clr_leg) cfg_q[CFG_LEG_EN] <= 1'b0;
            if (clr_hub) cfg_q[CFG_HUB_EN] <= 1'b0;
        end
    end

    assign done = (state_q == DET_DONE);

endmodule

// File: rtl/shm_window_decode.sv
module shm_window_decode
    import shm_pkg::*;
#(
    parameter int STRAP_W  = 2,
    parameter int SZ_W     = 5,
    parameter int MIN_LOG2 = 12,
    parameter int MAX_LOG2 = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] boot_strap,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [ADDR_W-1:0]  usr_base,
    input  logic [SZ_W-1:0]    usr_size_log2,
    input  logic               req_valid,
    input  logic               req_hub,
    input  logic               req_write,
    input  logic               req_done,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [ID_W-1:0]    req_id,
    output logic               hit,
    output logic [1:0]         region,
    output logic [ADDR_W-1:0]  xlat_addr,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic               det_done
);

    logic [CFG_W-1:0]  cfg_q;
    logic              usr_match;
    logic [ADDR_W-1:0] usr_xlat;
    logic              low_hit;
    logic              top_hit;
    logic [ADDR_W-1:0] fw_xlat;
    region_e           rgn;
    logic              fw_rd_evt;

    shm_user_zone #(
        .AW       (ADDR_W),
        .SZ_W     (SZ_W),
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) u_user (
        .enable    (cfg_q[CFG_USR_EN] && !req_hub),
        .addr      (req_addr),
        .base      (usr_base),
        .size_log2 (usr_size_log2),
        .match     (usr_match),
        .xlat      (usr_xlat)
    );

    shm_fw_ranges u_fw (
        .is_hub  (req_hub),
        .addr    (req_addr),
        .id      (req_id),
        .leg_en  (cfg_q[CFG_LEG_EN]),
        .ext_en  (cfg_q[CFG_EXT_EN]),
        .hub_en  (cfg_q[CFG_HUB_EN]),
        .hub_id  (cfg_q[CFG_ID_LO +: ID_W]),
        .low_hit (low_hit),
        .top_hit (top_hit),
        .xlat    (fw_xlat)
    );

    always_comb begin
        rgn       = RGN_NONE;
        xlat_addr = '0;
        if (req_valid) begin
            if (usr_match) begin
                rgn       = RGN_USER;
                xlat_addr = usr_xlat;
            end else if (low_hit) begin
                rgn       = RGN_LOWFW;
                xlat_addr = fw_xlat;
            end else if (top_hit) begin
                rgn       = RGN_TOPFW;
                xlat_addr = fw_xlat;
            end
        end
    end

    assign fw_rd_evt = req_valid && req_done && !req_write &&
                       ((rgn == RGN_LOWFW) || (rgn == RGN_TOPFW));

    shm_boot_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_on  (|boot_strap),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .fw_rd_evt (fw_rd_evt),
        .fw_rd_hub (req_hub),
        .cfg_q     (cfg_q),
        .done      (det_done)
    );

    assign hit       = (rgn != RGN_NONE);
    assign region    = rgn;
    assign cfg_rdata = cfg_q;

endmodule

// File: rtl/shm_window_decode_chk.sv
module shm_window_decode_chk #(
    parameter int STRAP_W = 2,
    parameter int SZ_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STRAP_W-1:0] boot_strap,
    input logic               cfg_we,
    input logic [7:0]         cfg_wdata,
    input logic [31:0]        usr_base,
    input logic [SZ_W-1:0]    usr_size_log2,
    input logic               req_valid,
    input logic               req_hub,
    input logic               req_write,
    input logic               req_done,
    input logic [31:0]        req_addr,
    input logic [3:0]         req_id,
    input logic               hit,
    input logic [1:0]         region,
    input logic [31:0]        xlat_addr,
    input logic [7:0]         cfg_rdata,
    input logic               det_done
);

    logic [4:0]  chk_sz;
    logic [31:0] chk_mask;

    always_comb begin
        if (usr_size_log2 < SZ_W'(12))      chk_sz = 5'd12;
        else if (usr_size_log2 > SZ_W'(24)) chk_sz = 5'd24;
        else                                chk_sz = 5'(usr_size_log2);
        chk_mask = (32'h1 << chk_sz) - 32'h1;
    end

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!hit && region == 2'd0 && xlat_addr == 32'h0));

    p_hub_top_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && req_hub) |-> (region == 2'd3 && xlat_addr[31:21] == 11'h7FF
                              && req_id == cfg_rdata[7:4]));

    p_user_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 2'd1) |-> ((xlat_addr | chk_mask) == 32'hFFFF_FFFF
                              && (xlat_addr & chk_mask) == (req_addr & chk_mask)));

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |=> det_done);

    p_miss_no_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_done && !hit) |=> !det_done);

    p_clear_hub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_done && req_valid && req_done && !req_write && !req_hub
         && region[1] && !cfg_we) |=> (det_done && !cfg_rdata[3]));

    p_clear_leg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_done && req_valid && req_done && !req_write && req_hub
         && hit && !cfg_we) |=> (det_done && !cfg_rdata[0]));

    p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

endmodule

bind shm_window_decode shm_window_decode_chk #(
    .STRAP_W (STRAP_W),
    .SZ_W    (SZ_W)
) u_chk (.*);

// File: tb/sim_shm_window_decode.sv
`timescale 1ns/1ps
module sim_shm_window_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_strap = 2'd1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h0;
    logic [31:0] usr_base = 32'h0;
    logic [4:0]  usr_size_log2 = 5'd12;
    logic        req_valid = 1'b0;
    logic        req_hub = 1'b0;
    logic        req_write = 1'b0;
    logic        req_done = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic [3:0]  req_id = 4'h0;
    logic        hit;
    logic [1:0]  region;
    logic [31:0] xlat_addr;
    logic [7:0]  cfg_rdata;
    logic        det_done;

    int vectors = 0;
    int errors  = 0;

    logic [7:0] m_cfg;
    logic       m_done;

    always #5 clk = ~clk;

    shm_window_decode u0 (.*);

    function automatic void model(output logic eh, output logic [1:0] er,
                                  output logic [31:0] ea);
        int sz;
        logic [31:0] mk;
        eh = 1'b0; er = 2'd0; ea = 32'h0;
        if (!req_valid) return;
        sz = (usr_size_log2 < 12) ? 12 : (usr_size_log2 > 24) ? 24 : int'(usr_size_log2);
        mk = (32'h1 << sz) - 1;
        if (!req_hub) begin
            if (m_cfg[1] && ((req_addr >> sz) == (usr_base >> sz))) begin
                er = 2'd1; ea = req_addr | ~mk;
            end else if (m_cfg[0] && (req_addr[31:16] == 16'h000F ||
                         (m_cfg[2] && req_addr[31:16] == 16'h000E))) begin
                er = 2'd2; ea = req_addr;
            end else if (m_cfg[0] && req_addr >= 32'hFFE0_0000) begin
                er = 2'd3; ea = req_addr;
            end
        end else if (m_cfg[3] && req_id == m_cfg[7:4]) begin
            er = 2'd3; ea = {11'h7FF, req_addr[20:0]};
        end
        eh = (er != 2'd0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [1:0] strap);
        rst_n = 1'b0;
        boot_strap = strap;
        req_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        m_cfg  = (strap != 0) ? 8'h09 : 8'h00;
        m_done = 1'b0;
        check("R1", 32'(cfg_rdata), 32'(m_cfg), "cfg in reset");
        check("R1", 32'(det_done), 32'h0, "det_done in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(cfg_rdata), 32'(m_cfg), "cfg after reset");
    endtask

    // one step: drive after the falling edge, compare decode 2 ns later,
    // advance the model on the rising edge, compare registers afterwards
    task automatic step(input string tag, input logic v, input logic hb, input logic wr,
                        input logic dn, input logic [31:0] a, input logic [3:0] id,
                        input logic we, input logic [7:0] wd);
        logic eh;
        logic [1:0] er;
        logic [31:0] ea;
        req_valid = v; req_hub = hb; req_write = wr; req_done = dn;
        req_addr = a; req_id = id; cfg_we = we; cfg_wdata = wd;
        #2;
        model(eh, er, ea);
        check(tag, 32'(hit), 32'(eh), "hit");
        check(tag, 32'(region), 32'(er), "region");
        check(tag, xlat_addr, ea, "xlat_addr");
        @(posedge clk);
        if (!m_done && v && dn && !wr && er[1]) begin
            if (hb) m_cfg[0] = 1'b0;
            else    m_cfg[3] = 1'b0;
            m_done = 1'b1;
        end
        if (we) m_cfg = wd;
        @(negedge clk);
        check(tag, 32'(cfg_rdata), 32'(m_cfg), "cfg_rdata");
        check(tag, 32'(det_done), 32'(m_done), "det_done");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1 strap zero: sharing disabled
        do_reset(2'd0);
        step("R12", 1, 0, 0, 1, 32'hFFFF_FFF0, 0, 0, 0);
        step("R12", 0, 0, 0, 1, 32'h000F_0000, 0, 0, 0);

        // R9 first memory-cycle firmware read clears the hub enable
        do_reset(2'd2);
        step("R11", 1, 0, 0, 0, 32'hFFFF_FFF0, 0, 0, 0);   // no done
        step("R11", 1, 0, 1, 1, 32'h000F_1234, 0, 0, 0);   // write
        step("R11", 1, 1, 0, 1, 32'h0012_3456, 4'h5, 0, 0); // wrong id miss
        step("R11", 1, 0, 0, 1, 32'h0010_0000, 0, 0, 0);   // miss
        step("R6",  1, 1, 0, 0, 32'h0012_3456, 4'h0, 0, 0);
        step("R9",  1, 0, 0, 1, 32'hFFFF_FFF0, 0, 0, 0);
        step("R6",  1, 1, 0, 1, 32'h0000_0100, 0, 0, 0);   // hub now disabled
        step("R2",  0, 0, 0, 0, 0, 0, 1, 8'h39);           // re-enable, id 3
        step("R11", 1, 1, 0, 1, 32'h001F_FFFF, 4'h3, 0, 0);
        step("R11", 1, 0, 0, 1, 32'h000F_8000, 0, 0, 0);
        step("R4",  1, 0, 0, 0, 32'h000E_4000, 0, 0, 0);
        step("R2",  0, 0, 0, 0, 0, 0, 1, 8'h3D);
        step("R4",  1, 0, 0, 0, 32'h000E_4000, 0, 0, 0);
        step("R3",  1, 0, 0, 0, 32'h000F_FFFF, 0, 0, 0);
        step("R5",  1, 0, 0, 0, 32'hFFE0_0000, 0, 0, 0);
        step("R5",  1, 0, 0, 0, 32'hFFDF_FFFF, 0, 0, 0);

        // R10 first hub read clears the memory-cycle enable; R2 write wins
        do_reset(2'd1);
        step("R10", 1, 1, 0, 1, 32'h000A_BCDE, 0, 0, 0);
        step("R10", 1, 0, 0, 1, 32'h000F_0000, 0, 0, 0);
        do_reset(2'd3);
        step("R2",  1, 0, 0, 1, 32'hFFFF_0000, 0, 1, 8'h0B);
        step("R11", 1, 1, 0, 1, 32'hFFFF_0000, 0, 0, 0);

        // R7 / R8 user zone, sizes and priority
        do_reset(2'd1);
        step("R2", 0, 0, 0, 0, 0, 0, 1, 8'h07);
        for (int s = 8; s < 28; s++) begin
            usr_size_log2 = 5'(s);
            usr_base = 32'h000F_0000;
            step("R7", 1, 0, 0, 1, 32'h000F_0ABC, 0, 0, 0);
            step("R8", 1, 0, 0, 0, 32'h000F_0000 ^ (32'h1 << (s % 32)), 0, 0, 0);
            usr_base = 32'h1234_5678;
            step("R7", 1, 0, 0, 0, 32'h1234_5000 | 32'(s), 0, 0, 0);
            step("R8", 1, 0, 0, 0, 32'h1230_0000, 0, 0, 0);
        end
        step("R7", 1, 1, 0, 0, 32'h1234_5678, 0, 0, 0);
        step("R9", 1, 0, 0, 1, 32'hFFFF_0000, 0, 0, 0);

        // mixed patterns
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            int pick = $urandom_range(0, 5);
            case (pick)
                0: a = 32'h000F_0000 | 32'($urandom_range(0, 65535));
                1: a = 32'h000E_0000 | 32'($urandom_range(0, 65535));
                2: a = 32'hFFE0_0000 | 32'($urandom_range(0, 32'h1F_FFFF));
                3: a = usr_base ^ 32'($urandom_range(0, 32'hFF_FFFF));
                default: a = $urandom;
            endcase
            if (n % 97 == 0) do_reset(2'($urandom_range(0, 3)));
            if (n % 40 == 5) usr_size_log2 = 5'($urandom_range(0, 31));
            step("R11", ($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
                 4'($urandom_range(0, 3)), ($urandom_range(0, 15) == 0), 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule